// File: doc/BRIEF.md
# I2C Command and Interrupt Handshake

This block is the processor-facing control core of a register-driven I2C controller. It keeps the enable, acknowledge, START request, STOP request, event flag and interrupt-enable bits. It also keeps the latest bus status code, a timeout flag and the bit-rate divider setting. A processor reaches these through a small synchronous write port and a combinational read port. The serial bus engine sits beside this block and reports to it through single-cycle strobes: start issued, STOP seen on the bus, new status code and timeout.

The block interlocks software with the engine. Each new status code raises the event flag. While that flag is set, the block holds the engine stalled. Software releases the engine by writing 1 to the flag, or the engine is released when a STOP completes. START and STOP requests clear themselves when the matching bus event arrives. Clearing the enable bit drops every pending request and flag at once.

Top module: `i2c_hs_top`

## Requirements
- R1: After reset, the control word (address 0) reads 0x00, the status code (address 1) reads 0x00, the divider (address 2) reads DIV_MIN, the timeout word (address 3) reads 0x00, and irq and engine_stall are 0.
- R2: A write to address 0 loads enable from bit 0, acknowledge from bit 1 and interrupt enable from bit 7. The control word reads back as {ien, 2'b00, event, START, STOP, ack, en}, and ack_out follows bit 1.
- R3: With the block enabled, writing 1 to bit 3 sets START (start_req); writing 0 to bit 3 leaves START unchanged. START clears on the first status update that comes with or after a start_done strobe. A status update with no start_done since the request leaves START set.
- R4: When is_master is 1, writing 1 to bit 2 sets STOP (stop_req). A stop_seen strobe clears it.
- R5: When is_master is 0, writing 1 to bit 2 raises slave_release for exactly one cycle and leaves STOP at 0.
- R6: While enabled, a status_valid strobe latches status_code into address 1, sets the event flag (bit 4) and asserts engine_stall.
- R7: Writing 1 to bit 4 clears the event flag and releases engine_stall. If a status_valid strobe arrives in the same cycle, the flag stays set.
- R8: A stop_seen strobe clears the event flag and releases engine_stall.
- R9: irq is 1 exactly when interrupt enable is 1 and the event flag or the timeout flag is set.
- R10: A timeout strobe sets the timeout flag (address 3, bit 0). Writing 1 to that bit clears it.
- R11: A divider write below DIV_MIN stores DIV_MIN; any other value is stored as written.
- R12: Writing 0 to the enable bit clears START, STOP, the event flag and the timeout flag, and deasserts engine_stall and irq. Bus strobes are ignored while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| is_master | input | 1 | Bus engine is in master mode |
| start_done | input | 1 | Engine has issued a START or repeated START |
| stop_seen | input | 1 | STOP condition detected on the bus |
| status_valid | input | 1 | New status code is present |
| status_code | input | 8 | Status code from the engine |
| timeout | input | 1 | Bus timeout strobe |
| enable_out | output | 1 | Controller enabled |
| ack_out | output | 1 | Acknowledge level to return on receive |
| start_req | output | 1 | START requested |
| stop_req | output | 1 | STOP requested |
| slave_release | output | 1 | One-cycle pulse that returns the slave to not-addressed |
| engine_stall | output | 1 | Freeze the bus engine |
| div_out | output | DIV_W | Bit-rate divider setting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default DIV_W of 8 and DIV_MIN of 4. This puts the clamp boundary at reachable values: 2 and 3 must read back as 4, while 4 and 0x40 are stored as written. The 8-bit width lets the bench drive arbitrary status codes. With these values the bench can also make a status strobe and a flag-clear write coincide, place start_done before or together with a status update, and pulse stop_seen in both master and slave mode.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_CODE = 2'd1,
        REG_DIV  = 2'd2,
        REG_TOUT = 2'd3
    } hs_reg_e;

    localparam int BIT_EN    = 0;
    localparam int BIT_ACK   = 1;
    localparam int BIT_STOP  = 2;
    localparam int BIT_START = 3;
    localparam int BIT_EVT   = 4;
    localparam int BIT_IEN   = 7;

    typedef struct packed {
        logic ien;
        logic evt;
        logic start;
        logic stop;
        logic ack;
        logic en;
    } hs_ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(hs_ctrl_t c);
        logic [REG_W-1:0] w;
        w            = '0;
        w[BIT_EN]    = c.en;
        w[BIT_ACK]   = c.ack;
        w[BIT_STOP]  = c.stop;
        w[BIT_START] = c.start;
        w[BIT_EVT]   = c.evt;
        w[BIT_IEN]   = c.ien;
        return w;
    endfunction

endpackage

// File: rtl/hs_ctrl_bits.sv
module hs_ctrl_bits
    import i2c_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             is_master,
    input  logic             start_done,
    input  logic             stop_seen,
    input  logic             status_valid,
    output hs_ctrl_t         ctrl_q,
    output logic             release_q
);

    hs_ctrl_t c_n;
    logic     pend_q, pend_n, rel_n;

    always_comb begin
        c_n    = ctrl_q;
        pend_n = pend_q;
        rel_n  = 1'b0;
        if (wr_ctrl) begin
            c_n.en  = wdata[BIT_EN];
            c_n.ack = wdata[BIT_ACK];
            c_n.ien = wdata[BIT_IEN];
            if (wdata[BIT_EN]) begin
                if (wdata[BIT_START]) c_n.start = 1'b1;
                if (wdata[BIT_STOP]) begin
                    if (is_master) c_n.stop = 1'b1;
                    else           rel_n    = 1'b1;
                end
                if (wdata[BIT_EVT]) c_n.evt = 1'b0;
            end
        end
        if (ctrl_q.en && c_n.en) begin
            if (stop_seen) begin
                c_n.stop = 1'b0;
                c_n.evt  = 1'b0;
            end
            if (start_done) pend_n = 1'b1;
            if (status_valid) begin
                c_n.evt = 1'b1;
                if (c_n.start && (start_done || pend_q)) begin
                    c_n.start = 1'b0;
                    pend_n    = 1'b0;
                end
            end
        end
        if (!c_n.en) begin
            c_n.start = 1'b0;
            c_n.stop  = 1'b0;
            c_n.evt   = 1'b0;
            pend_n    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            pend_q    <= 1'b0;
            release_q <= 1'b0;
        end else begin
            ctrl_q    <= c_n;
            pend_q    <= pend_n;
            release_q <= rel_n;
        end
    end

endmodule

// File: rtl/hs_status_latch.sv
module hs_status_latch
    import i2c_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             status_valid,
    input  logic [REG_W-1:0] code_in,
    input  logic             timeout,
    input  logic             wr_tout,
    input  logic             clr_bit,
    output logic [REG_W-1:0] code_q,
    output logic             tflag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            tflag_q <= 1'b0;
        end else begin
            if (en && status_valid) code_q <= code_in;
            if (!en)                   tflag_q <= 1'b0;
            else if (timeout)          tflag_q <= 1'b1;
            else if (wr_tout && clr_bit) tflag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_div_reg.sv
module hs_div_reg #(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_div,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q
);

    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(DIV_MIN);

    always_ff @(posedge clk) begin
        if (rst)         div_q <= FLOOR;
        else if (wr_div) div_q <= (wdata < FLOOR) ? FLOOR : wdata;
    end

endmodule

// File: rtl/i2c_hs_top.sv
module i2c_hs_top
    import i2c_hs_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              is_master,
    input  logic              start_done,
    input  logic              stop_seen,
    input  logic              status_valid,
    input  logic [7:0]        status_code,
    input  logic              timeout,
    output logic              enable_out,
    output logic              ack_out,
    output logic              start_req,
    output logic              stop_req,
    output logic              slave_release,
    output logic              engine_stall,
    output logic [DIV_W-1:0]  div_out,
    output logic              irq
);

    hs_reg_e          sel;
    hs_ctrl_t         ctrl_q;
    logic [REG_W-1:0] code_q;
    logic             tflag_q;
    logic             wr_ctrl, wr_div, wr_tout;

    assign sel     = hs_reg_e'(reg_addr);
    assign wr_ctrl = reg_wr && (sel == REG_CTRL);
    assign wr_div  = reg_wr && (sel == REG_DIV);
    assign wr_tout = reg_wr && (sel == REG_TOUT);

    hs_ctrl_bits u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_ctrl),
        .wdata        (reg_wdata),
        .is_master    (is_master),
        .start_done   (start_done),
        .stop_seen    (stop_seen),
        .status_valid (status_valid),
        .ctrl_q       (ctrl_q),
        .release_q    (slave_release)
    );

    hs_status_latch u_stat (
        .clk          (clk),
        .rst          (rst),
        .en           (ctrl_q.en),
        .status_valid (status_valid),
        .code_in      (status_code),
        .timeout      (timeout),
        .wr_tout      (wr_tout),
        .clr_bit      (reg_wdata[0]),
        .code_q       (code_q),
        .tflag_q      (tflag_q)
    );

    hs_div_reg #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_div (
        .clk    (clk),
        .rst    (rst),
        .wr_div (wr_div),
        .wdata  (reg_wdata[DIV_W-1:0]),
        .div_q  (div_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CTRL: reg_rdata = pack_ctrl(ctrl_q);
            REG_CODE: reg_rdata = code_q;
            REG_DIV:  reg_rdata = 8'(div_out);
            REG_TOUT: reg_rdata = {7'b0, tflag_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign enable_out   = ctrl_q.en;
    assign ack_out      = ctrl_q.ack;
    assign start_req    = ctrl_q.start;
    assign stop_req     = ctrl_q.stop;
    assign engine_stall = ctrl_q.en && ctrl_q.evt;
    assign irq          = ctrl_q.en && ctrl_q.ien && (ctrl_q.evt || tflag_q);

endmodule

// File: rtl/i2c_hs_chk.sv
module i2c_hs_chk
    import i2c_hs_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             is_master,
    input logic             stop_seen,
    input logic             status_valid,
    input logic             enable_out,
    input logic             start_req,
    input logic             stop_req,
    input logic             slave_release,
    input logic             engine_stall,
    input logic [DIV_W-1:0] div_out,
    input logic             irq,
    input hs_ctrl_t         ctrl_q
);

    logic ctrl_touch;
    assign ctrl_touch = reg_wr && (reg_addr == REG_CTRL);

    assert_stall_on_event_R6: assert property (@(posedge clk) disable iff (rst)
        (enable_out && status_valid && !(ctrl_touch && !reg_wdata[BIT_EN])) |=> engine_stall);

    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (enable_out && is_master && stop_seen && !ctrl_touch) |=> !stop_req);

    assert_irq_follows_event_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ien && enable_out && status_valid && !ctrl_touch) |=> irq);

    assert_div_floor_R11: assert property (@(posedge clk) disable iff (rst)
        div_out >= DIV_W'(DIV_MIN));

    assert_release_single_R5: assert property (@(posedge clk) disable iff (rst)
        slave_release |=> !slave_release);

    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !enable_out |-> (!start_req && !stop_req && !engine_stall && !irq));

endmodule

bind i2c_hs_top i2c_hs_chk #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .is_master     (is_master),
    .stop_seen     (stop_seen),
    .status_valid  (status_valid),
    .enable_out    (enable_out),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .slave_release (slave_release),
    .engine_stall  (engine_stall),
    .div_out       (div_out),
    .irq           (irq),
    .ctrl_q        (ctrl_q)
);

// File: tb/tb_i2c_hs_top.sv
module tb_i2c_hs_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       is_master, start_done, stop_seen, status_valid, timeout;
    logic [7:0] status_code;
    logic       enable_out, ack_out, start_req, stop_req, slave_release, engine_stall, irq;
    logic [7:0] div_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0] a;
        logic [7:0] e;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    i2c_hs_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .is_master(is_master),
        .start_done(start_done), .stop_seen(stop_seen), .status_valid(status_valid),
        .status_code(status_code), .timeout(timeout), .enable_out(enable_out),
        .ack_out(ack_out), .start_req(start_req), .stop_req(stop_req),
        .slave_release(slave_release), .engine_stall(engine_stall),
        .div_out(div_out), .irq(irq)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // monitor: compares queued read expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk(reg_rdata, it.e, it.tag);
            end
        end
    end

    // driver side: select address, push expectation, wait for monitor
    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                       input logic sv, input logic [7:0] code, input logic sd,
                       input logic ss, input logic to);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        status_valid = sv; status_code = code; start_done = sd;
        stop_seen = ss; timeout = to;
        @(negedge clk);
        reg_wr = 0; status_valid = 0; start_done = 0; stop_seen = 0; timeout = 0;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1, a, d, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic ev(input logic sv, input logic [7:0] code, input logic sd,
                      input logic ss, input logic to);
        cyc(0, 2'd0, 8'h00, sv, code, sd, ss, to);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; is_master = 1;
        start_done = 0; stop_seen = 0; status_valid = 0; status_code = 0; timeout = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(irq, 0, "R1 irq");
        chk(engine_stall, 0, "R1 stall");
        expect_rd(0, 8'h00, "R1 ctrl");
        expect_rd(1, 8'h00, "R1 code");
        expect_rd(2, 8'h04, "R1 div");
        expect_rd(3, 8'h00, "R1 tout");

        // R2 control bits
        wr(0, 8'h83);
        chk(ack_out, 1, "R2 ack_out");
        chk(enable_out, 1, "R2 enable_out");
        expect_rd(0, 8'h83, "R2 ctrl readback");

        // R11 divider clamp
        wr(2, 8'h02); expect_rd(2, 8'h04, "R11 div 2");
        wr(2, 8'h03); expect_rd(2, 8'h04, "R11 div 3");
        wr(2, 8'h04); expect_rd(2, 8'h04, "R11 div 4");
        wr(2, 8'h40); expect_rd(2, 8'h40, "R11 div 0x40");

        // R6 / R9 status event
        ev(1, 8'h08, 0, 0, 0);
        chk(engine_stall, 1, "R6 stall");
        chk(irq, 1, "R9 irq on event");
        expect_rd(1, 8'h08, "R6 code");
        expect_rd(0, 8'h93, "R6 flag bit");

        // R7 clear by writing 1
        wr(0, 8'h93);
        chk(engine_stall, 0, "R7 stall released");
        chk(irq, 0, "R9 irq cleared");
        expect_rd(0, 8'h83, "R7 ctrl");

        // R7 simultaneous event and clear: event wins
        cyc(1, 2'd0, 8'h93, 1, 8'h10, 0, 0, 0);
        chk(engine_stall, 1, "R7 set wins");
        expect_rd(1, 8'h10, "R6 code second");
        wr(0, 8'h93);

        // R3 START handshake
        wr(0, 8'h8B);
        chk(start_req, 1, "R3 start set");
        ev(1, 8'h20, 0, 0, 0);
        chk(start_req, 1, "R3 no start_done keeps start");
        wr(0, 8'h93);
        chk(start_req, 1, "R3 write 0 no effect");
        ev(0, 8'h00, 1, 0, 0);
        chk(start_req, 1, "R3 start_done alone");
        ev(1, 8'h08, 0, 0, 0);
        chk(start_req, 0, "R3 cleared on status");
        expect_rd(0, 8'h93, "R3 ctrl after start");
        wr(0, 8'h93);
        wr(0, 8'h8B);
        ev(1, 8'h18, 1, 0, 0);
        chk(start_req, 0, "R3 same-cycle start_done");
        wr(0, 8'h93);

        // R4 / R8 STOP master
        is_master = 1;
        wr(0, 8'h87);
        chk(stop_req, 1, "R4 stop set");
        ev(1, 8'h28, 0, 0, 0);
        chk(engine_stall, 1, "R8 stall before stop");
        ev(0, 8'h00, 0, 1, 0);
        chk(stop_req, 0, "R4 stop cleared");
        chk(engine_stall, 0, "R8 stall released by stop");

        // R5 slave release
        is_master = 0;
        wr(0, 8'h87);
        chk(slave_release, 1, "R5 pulse");
        chk(stop_req, 0, "R5 stop stays 0");
        @(negedge clk); #1;
        chk(slave_release, 0, "R5 single cycle");
        is_master = 1;

        // R10 / R9 timeout flag
        wr(0, 8'h03);
        ev(0, 8'h00, 0, 0, 1);
        expect_rd(3, 8'h01, "R10 tflag set");
        chk(irq, 0, "R9 ien off");
        wr(0, 8'h83);
        chk(irq, 1, "R9 irq by timeout");
        wr(3, 8'h01);
        expect_rd(3, 8'h00, "R10 tflag cleared");
        chk(irq, 0, "R9 irq after tflag clear");

        // R12 disable
        wr(0, 8'h8F);
        ev(1, 8'h30, 0, 0, 1);
        chk(engine_stall, 1, "R12 pre stall");
        wr(0, 8'h00);
        chk(start_req, 0, "R12 start");
        chk(stop_req, 0, "R12 stop");
        chk(engine_stall, 0, "R12 stall");
        chk(irq, 0, "R12 irq");
        expect_rd(0, 8'h00, "R12 ctrl");
        expect_rd(3, 8'h00, "R12 tflag");
        ev(1, 8'h55, 0, 0, 1);
        chk(engine_stall, 0, "R12 ignored event");
        expect_rd(1, 8'h30, "R12 code unchanged");
        expect_rd(0, 8'h00, "R12 ctrl unchanged");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule